// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block walks one PLL through a safe change of divider settings over a simple register bus. When a request is accepted it latches a 24-bit divider word and a VCO frequency in kHz. It then turns the PLL output off and picks the VCO band from that frequency. Next it rewrites the divider half of the control pair, with the calibration and update-enable bits set. It polls the status word until the PLL reports lock and then until it stops reporting an update in progress. Last, it turns the output back on. Every register change is a read followed by a write, so the bits the sequence does not own keep their values.

Status polling is paced by a one-cycle microsecond tick from outside the block. Each of the two waits has its own tick budget. If a wait runs out, the block remembers a warning, abandons the remaining wait and still re-enables the output. A build-time switch turns an instance into a read-only one. Such an instance refuses every request and never touches the bus.

States: IDLE, EN_RD, EN_CLR, LO_RD, LO_WR, HI_RD, HI_WR, LOCK_RD, LOCK_WAIT, UPD_RD, UPD_WAIT, EN_RD2, EN_SET, FINISH, REJECT.

Transitions:
- IDLE goes to EN_RD on start, or to REJECT when the instance is read-only.
- Each bus state moves on when `bus_ack` arrives: EN_RD→EN_CLR→LO_RD→LO_WR→HI_RD→HI_WR→LOCK_RD.
- LOCK_RD goes to UPD_RD if the lock bit is 1, otherwise to LOCK_WAIT.
- LOCK_WAIT goes back to LOCK_RD on a tick, or to EN_RD2 on a tick that exhausts the budget.
- UPD_RD goes to EN_RD2 if the updating bit is 0, otherwise to UPD_WAIT.
- UPD_WAIT goes back to UPD_RD on a tick, or to EN_RD2 on a tick that exhausts the budget.
- EN_RD2→EN_SET→FINISH, each on `bus_ack`.
- FINISH and REJECT return to IDLE after one cycle.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `warn`, `rejected` and `bus_req` are all 0.
- R2: `start` is taken only while idle. `busy` is 1 from the cycle after acceptance through the `done` cycle and 0 in the cycle after it. A `start` seen while busy has no effect on any register written.
- R3: The first write goes to the enable register (SYS_BASE+EN_OFS). It carries the value just read with bit EN_BIT cleared and all other bits kept.
- R4: The second write goes to the low control register (SYS_BASE+CTRL_OFS). Bits [17:16] become 2 when `vco_khz` < BAND_KHZ and 3 otherwise. All other bits are kept.
- R5: The third write goes to the high control register, 4 bytes above the low one. It carries [23:0]=`div_word`, bit 24=1, [29:27]=2 and bit 30=1. Bits 25, 26 and 31 keep the values read.
- R6: After the high write the block reads the status register (SYS_BASE+STAT_OFS) and waits until bit LOCK_BIT reads 1. It reads again once per tick. If TIMEOUT_US ticks pass without lock, it sets the warning and skips the update wait.
- R7: After lock it waits, under a fresh TIMEOUT_US budget, until status bit UPD_BIT reads 0. Running out sets the warning.
- R8: The fourth and last write goes to the enable register with bit EN_BIT set and all other bits kept. This happens even after a timeout. `done` then pulses for one cycle, and `warn` is 1 only in that cycle and only if a wait timed out.
- R9: Only one bus request is outstanding at a time. While `bus_req` is 1 and `bus_ack` is 0, the address, direction and write data hold steady.
- R10: A read-only instance (READ_ONLY=1) answers `start` with a one-cycle `rejected` pulse in the next cycle. It never raises `bus_req`, `busy` or `done`.
- R11: Each accepted request makes exactly four writes, in the order enable, low control, high control, enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken when idle |
| div_word | input | 24 | Divider fields for high control [23:0] |
| vco_khz | input | VCO_W | VCO frequency in kHz, used for the band choice |
| usec_tick | input | 1 | One-cycle pulse each microsecond |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| warn | output | 1 | Timeout warning, valid with `done` |
| rejected | output | 1 | One-cycle refusal pulse for a read-only instance |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |

## Verification
`busy` rises one clock after the accepting edge, and `rejected` comes one clock after `start` on a read-only instance. The bench samples both at the following falling edge. Bus timing is variable: the bench's register model acks after a random 0 to 2 cycle latency, and the PLL model reports lock and update completion a random number of ticks after the high write. So the bench does not predict the cycle of `done`. It waits for `done` at falling edges, samples `warn` in that same cycle, and checks `busy` one cycle later. Register contents and write order come from a log the bus model keeps, compared with values computed from the preloaded words. The lock-timeout case also checks that the number of ticks from start to `done` lies within a few ticks above TIMEOUT_US.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_EN_RD, ST_EN_CLR, ST_LO_RD, ST_LO_WR, ST_HI_RD, ST_HI_WR,
        ST_LOCK_RD, ST_LOCK_WAIT, ST_UPD_RD, ST_UPD_WAIT, ST_EN_RD2,
        ST_EN_SET, ST_FINISH, ST_REJECT
    } seq_state_e;

    localparam int unsigned DIV_W     = 24;
    localparam int unsigned BAND_LSB  = 16;
    localparam logic [1:0]  BAND_LOW  = 2'd2;
    localparam logic [1:0]  BAND_HIGH = 2'd3;
    localparam logic [2:0]  CAL_VALUE = 3'd2;
    // bits replaced in the high control word: [23:0], 24, [29:27], 30
    localparam logic [31:0] HI_OWNED  = 32'h79FF_FFFF;

    function automatic logic is_bus_state(seq_state_e s);
        return (s == ST_EN_RD)  || (s == ST_EN_CLR) || (s == ST_LO_RD) ||
               (s == ST_LO_WR)  || (s == ST_HI_RD)  || (s == ST_HI_WR) ||
               (s == ST_LOCK_RD) || (s == ST_UPD_RD) || (s == ST_EN_RD2) ||
               (s == ST_EN_SET);
    endfunction

endpackage

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
    parameter int unsigned LIMIT = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last_tick
);
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] MAXV  = CNT_W'(LIMIT);
    localparam logic [CNT_W-1:0] FINAL = CNT_W'(LIMIT - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc && cnt_q != MAXV) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign last_tick = (cnt_q >= FINAL);
endmodule

// File: rtl/pll_word_fmt.sv
module pll_word_fmt
    import pll_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_ADDR = '0,
    parameter logic [ADDR_W-1:0] HI_ADDR = '0,
    parameter logic [ADDR_W-1:0] ST_ADDR = '0,
    parameter logic [ADDR_W-1:0] EN_ADDR = '0,
    parameter int unsigned EN_BIT = 0
) (
    input  seq_state_e        state,
    input  logic [31:0]       shadow,
    input  logic [DIV_W-1:0]  div,
    input  logic              band_hi,
    output logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic [31:0]       wdata
);
    localparam logic [31:0] EN_MASK = 32'(1) << EN_BIT;

    logic [31:0] hi_fields;
    assign hi_fields = {1'b0, 1'b1, CAL_VALUE, 2'b00, 1'b1, div};

    always_comb begin
        we    = 1'b0;
        addr  = EN_ADDR;
        wdata = shadow;
        unique case (state)
            ST_EN_RD, ST_EN_RD2: addr = EN_ADDR;
            ST_EN_CLR: begin
                we    = 1'b1;
                wdata = shadow & ~EN_MASK;
            end
            ST_LO_RD: addr = LO_ADDR;
            ST_LO_WR: begin
                we    = 1'b1;
                addr  = LO_ADDR;
                wdata[BAND_LSB +: 2] = band_hi ? BAND_HIGH : BAND_LOW;
            end
            ST_HI_RD: addr = HI_ADDR;
            ST_HI_WR: begin
                we    = 1'b1;
                addr  = HI_ADDR;
                wdata = (shadow & ~HI_OWNED) | hi_fields;
            end
            ST_LOCK_RD, ST_UPD_RD: addr = ST_ADDR;
            ST_EN_SET: begin
                we    = 1'b1;
                wdata = shadow | EN_MASK;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pll_seq_fsm.sv
module pll_seq_fsm
    import pll_seq_pkg::*;
#(
    parameter bit READ_ONLY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       bus_ack,
    input  logic       poll_bit,
    input  logic       tick,
    input  logic       last_tick,
    output seq_state_e state,
    output logic       accept,
    output logic       busy,
    output logic       done,
    output logic       rejected,
    output logic       bus_req,
    output logic       tmr_clr,
    output logic       tmr_inc,
    output logic       warn_flag
);
    seq_state_e state_q, state_d;
    logic       warn_q;
    logic       expire;

    assign state  = state_q;
    assign accept = (state_q == ST_IDLE) && start;
    assign expire = tick && last_tick &&
                    (state_q == ST_LOCK_WAIT || state_q == ST_UPD_WAIT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start) state_d = READ_ONLY ? ST_REJECT : ST_EN_RD;
            ST_EN_RD:     if (bus_ack) state_d = ST_EN_CLR;
            ST_EN_CLR:    if (bus_ack) state_d = ST_LO_RD;
            ST_LO_RD:     if (bus_ack) state_d = ST_LO_WR;
            ST_LO_WR:     if (bus_ack) state_d = ST_HI_RD;
            ST_HI_RD:     if (bus_ack) state_d = ST_HI_WR;
            ST_HI_WR:     if (bus_ack) state_d = ST_LOCK_RD;
            ST_LOCK_RD:   if (bus_ack) state_d = poll_bit ? ST_UPD_RD : ST_LOCK_WAIT;
            ST_LOCK_WAIT: if (tick) state_d = last_tick ? ST_EN_RD2 : ST_LOCK_RD;
            ST_UPD_RD:    if (bus_ack) state_d = poll_bit ? ST_UPD_WAIT : ST_EN_RD2;
            ST_UPD_WAIT:  if (tick) state_d = last_tick ? ST_EN_RD2 : ST_UPD_RD;
            ST_EN_RD2:    if (bus_ack) state_d = ST_EN_SET;
            ST_EN_SET:    if (bus_ack) state_d = ST_FINISH;
            ST_FINISH:    state_d = ST_IDLE;
            ST_REJECT:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            warn_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept)      warn_q <= 1'b0;
            else if (expire) warn_q <= 1'b1;
        end
    end

    always_comb begin
        busy     = (state_q != ST_IDLE) && (state_q != ST_REJECT);
        done     = (state_q == ST_FINISH);
        rejected = (state_q == ST_REJECT);
        bus_req  = is_bus_state(state_q);
        tmr_clr  = (state_q == ST_HI_WR) ||
                   (state_q == ST_LOCK_RD && bus_ack && poll_bit);
        tmr_inc  = tick && (state_q == ST_LOCK_RD || state_q == ST_LOCK_WAIT ||
                            state_q == ST_UPD_RD  || state_q == ST_UPD_WAIT);
        warn_flag = warn_q;
    end
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned VCO_W      = 32,
    parameter logic [ADDR_W-1:0] SYS_BASE = 12'h098,
    parameter logic [ADDR_W-1:0] CTRL_OFS = 12'h030,
    parameter logic [ADDR_W-1:0] STAT_OFS = 12'h000,
    parameter logic [ADDR_W-1:0] EN_OFS   = 12'h004,
    parameter int unsigned LOCK_BIT   = 17,
    parameter int unsigned UPD_BIT    = 1,
    parameter int unsigned EN_BIT     = 1,
    parameter int unsigned TIMEOUT_US = 100000,
    parameter int unsigned BAND_KHZ   = 2400000,
    parameter bit          READ_ONLY  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [23:0]       div_word,
    input  logic [VCO_W-1:0]  vco_khz,
    input  logic              usec_tick,
    output logic              busy,
    output logic              done,
    output logic              warn,
    output logic              rejected,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [31:0]       bus_wdata,
    input  logic [31:0]       bus_rdata,
    input  logic              bus_ack
);
    localparam logic [ADDR_W-1:0] LO_ADDR = SYS_BASE + CTRL_OFS;
    localparam logic [ADDR_W-1:0] HI_ADDR = SYS_BASE + CTRL_OFS + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] ST_ADDR = SYS_BASE + STAT_OFS;
    localparam logic [ADDR_W-1:0] EN_ADDR = SYS_BASE + EN_OFS;
    localparam logic [VCO_W-1:0]  BAND_LIM = VCO_W'(BAND_KHZ);

    seq_state_e       state;
    logic             accept, tmr_clr, tmr_inc, last_tick, warn_flag, poll_bit;
    logic [31:0]      shadow_q;
    logic [DIV_W-1:0] div_q;
    logic             band_q;

    assign poll_bit = (state == ST_LOCK_RD) ? bus_rdata[LOCK_BIT] : bus_rdata[UPD_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow_q <= '0;
            div_q    <= '0;
            band_q   <= 1'b0;
        end else begin
            if (accept) begin
                div_q  <= div_word;
                band_q <= (vco_khz >= BAND_LIM);
            end
            if (bus_req && bus_ack && !bus_we) shadow_q <= bus_rdata;
        end
    end

    pll_seq_fsm #(.READ_ONLY(READ_ONLY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .bus_ack(bus_ack),
        .poll_bit(poll_bit), .tick(usec_tick), .last_tick(last_tick),
        .state(state), .accept(accept), .busy(busy), .done(done),
        .rejected(rejected), .bus_req(bus_req), .tmr_clr(tmr_clr),
        .tmr_inc(tmr_inc), .warn_flag(warn_flag)
    );

    pll_poll_timer #(.LIMIT(TIMEOUT_US)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc),
        .last_tick(last_tick)
    );

    pll_word_fmt #(
        .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR),
        .ST_ADDR(ST_ADDR), .EN_ADDR(EN_ADDR), .EN_BIT(EN_BIT)
    ) u_fmt (
        .state(state), .shadow(shadow_q), .div(div_q), .band_hi(band_q),
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata)
    );

    assign warn = done && warn_flag;
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter logic [ADDR_W-1:0] LO_ADDR = '0,
    parameter logic [ADDR_W-1:0] HI_ADDR = '0,
    parameter bit READ_ONLY = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              warn,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_ack
);
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                   $stable(bus_we) && $stable(bus_wdata)));

    assert_hi_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == HI_ADDR) |->
            (bus_wdata[24] && bus_wdata[29:27] == 3'd2 && bus_wdata[30]));

    assert_band_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == LO_ADDR) |->
            (bus_wdata[17:16] == 2'd2 || bus_wdata[17:16] == 2'd3));

    assert_warn_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        warn |-> done);

    assert_done_then_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !READ_ONLY) |=> busy);

    assert_ro_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        READ_ONLY |-> (!bus_req && !busy));
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR), .READ_ONLY(READ_ONLY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .warn(warn), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack)
);

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TB_TIMEOUT = 24;
    localparam int TICK_EVERY = 4;
    localparam logic [11:0] LO_A = 12'h0C8;
    localparam logic [11:0] HI_A = 12'h0CC;
    localparam logic [11:0] ST_A = 12'h098;
    localparam logic [11:0] EN_A = 12'h09C;
    localparam int LOCK_B = 17;
    localparam int UPD_B  = 1;
    localparam int EN_B   = 1;
    localparam int NEVER  = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, start_ro = 1'b0;
    logic [23:0] div_word = '0;
    logic [31:0] vco_khz = '0;
    logic usec_tick = 1'b0;
    logic busy, done, warn, rejected, bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic bus_ack = 1'b0;
    logic busy_ro, done_ro, warn_ro, rej_ro, req_ro, we_ro;
    logic [11:0] addr_ro;
    logic [31:0] wdata_ro;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_reprog_seq #(.TIMEOUT_US(TB_TIMEOUT)) i_pll_reprog_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .div_word(div_word),
        .vco_khz(vco_khz), .usec_tick(usec_tick), .busy(busy), .done(done),
        .warn(warn), .rejected(rejected), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    pll_reprog_seq #(.TIMEOUT_US(TB_TIMEOUT), .READ_ONLY(1'b1)) i_pll_reprog_seq_ro (
        .clk(clk), .rst_n(rst_n), .start(start_ro), .div_word(div_word),
        .vco_khz(vco_khz), .usec_tick(usec_tick), .busy(busy_ro), .done(done_ro),
        .warn(warn_ro), .rejected(rej_ro), .bus_req(req_ro), .bus_we(we_ro),
        .bus_addr(addr_ro), .bus_wdata(wdata_ro), .bus_rdata(32'h0),
        .bus_ack(1'b0)
    );

    // register and PLL model
    int tick_div = 0;
    always @(posedge clk) begin
        tick_div  <= (tick_div == TICK_EVERY - 1) ? 0 : tick_div + 1;
        usec_tick <= (tick_div == TICK_EVERY - 1);
    end

    logic        load = 1'b0;
    logic [31:0] pre_en, pre_lo, pre_hi;
    logic [31:0] r_en, r_lo, r_hi;
    int lock_d = 0, upd_d = 0;
    int pll_cnt = 0, tick_cnt = 0, lat = 0, wn = 0;
    logic [11:0] wlog_a [0:7];
    logic [31:0] wlog_d [0:7];
    logic [31:0] status_w;

    always_comb begin
        status_w = 32'h0000_0000;
        status_w[LOCK_B] = (pll_cnt >= lock_d);
        status_w[UPD_B]  = (pll_cnt < lock_d + upd_d);
    end

    always @(posedge clk) begin
        bus_ack <= 1'b0;
        if (usec_tick) begin
            if (pll_cnt < NEVER) pll_cnt <= pll_cnt + 1;
            tick_cnt <= tick_cnt + 1;
        end
        if (load) begin
            r_en <= pre_en; r_lo <= pre_lo; r_hi <= pre_hi;
            wn <= 0; tick_cnt <= 0; pll_cnt <= 0;
        end else if (bus_req && !bus_ack) begin
            if (lat != 0) begin
                lat <= lat - 1;
            end else begin
                bus_ack <= 1'b1;
                lat <= int'($urandom_range(0, 2));
                if (bus_we) begin
                    if (wn < 8) begin
                        wlog_a[wn] <= bus_addr;
                        wlog_d[wn] <= bus_wdata;
                    end
                    wn <= wn + 1;
                    if (bus_addr == EN_A) r_en <= bus_wdata;
                    if (bus_addr == LO_A) r_lo <= bus_wdata;
                    if (bus_addr == HI_A) begin
                        r_hi <= bus_wdata;
                        pll_cnt <= 0;
                    end
                end else begin
                    bus_rdata <= (bus_addr == EN_A) ? r_en :
                                 (bus_addr == LO_A) ? r_lo :
                                 (bus_addr == HI_A) ? r_hi :
                                 (bus_addr == ST_A) ? status_w : 32'h0;
                end
            end
        end
    end

    int n_checks = 0, n_errors = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_lo(input logic [31:0] pre, input logic [31:0] vk);
        logic [31:0] v = pre;
        v[17:16] = (vk < 32'd2400000) ? 2'd2 : 2'd3;
        return v;
    endfunction

    function automatic logic [31:0] exp_hi(input logic [31:0] pre, input logic [23:0] dv);
        logic [31:0] v = pre;
        v[23:0] = dv; v[24] = 1'b1; v[29:27] = 3'd2; v[30] = 1'b1;
        return v;
    endfunction

    task automatic run_case(input logic [23:0] dv, input logic [31:0] vk,
                            input int ld, input int ud, input bit exp_warn,
                            input bit poke, input bit check_ticks);
        bit seen = 1'b0;
        @(negedge clk);
        pre_en = $urandom | (32'(1) << EN_B);
        pre_lo = $urandom;
        pre_hi = $urandom;
        lock_d = ld; upd_d = ud;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0; start = 1'b1; div_word = dv; vco_khz = vk;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R2", "busy after start", 32'(busy), 32'h1);
        if (poke) begin
            repeat (3) @(negedge clk);
            start = 1'b1; div_word = ~dv; vco_khz = ~vk;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 3000 && !seen; i++) begin
            if (done === 1'b1) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen, "R8", "done pulse", 32'(seen), 32'h1);
        if (!seen) return;
        check(warn === exp_warn, exp_warn ? "R6/R7" : "R8", "warn at done",
              32'(warn), 32'(exp_warn));
        if (check_ticks)
            check(tick_cnt >= TB_TIMEOUT && tick_cnt <= TB_TIMEOUT + 6, "R6",
                  "ticks to lock timeout", 32'(tick_cnt), 32'(TB_TIMEOUT));
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R2", "idle after done",
              {30'h0, busy, done}, 32'h0);
        check(wn == 4, "R11", "write count", 32'(wn), 32'd4);
        if (wn == 4) begin
            check(wlog_a[0] == EN_A && wlog_d[0] == (pre_en & ~(32'(1) << EN_B)),
                  "R3", "enable clear write", wlog_d[0], pre_en & ~(32'(1) << EN_B));
            check(wlog_a[1] == LO_A && wlog_d[1] == exp_lo(pre_lo, vk),
                  "R4", "band select write", wlog_d[1], exp_lo(pre_lo, vk));
            check(wlog_a[2] == HI_A && wlog_d[2] == exp_hi(pre_hi, dv),
                  poke ? "R2" : "R5", "high control write", wlog_d[2], exp_hi(pre_hi, dv));
            check(wlog_a[3] == EN_A && wlog_d[3] == pre_en,
                  "R8", "enable set write", wlog_d[3], pre_en);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2917));
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && warn === 1'b0 && bus_req === 1'b0 &&
              rejected === 1'b0, "R1", "outputs in reset",
              {27'h0, busy, done, warn, bus_req, rejected}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && bus_req === 1'b0, "R1", "idle after reset",
              {30'h0, busy, bus_req}, 32'h0);

        // directed corners
        run_case(24'h00_0A1B, 32'd2399999, 0, 0, 1'b0, 1'b0, 1'b0); // R4 band 2
        run_case(24'hFF_FFFF, 32'd2400000, 3, 2, 1'b0, 1'b0, 1'b0); // R4 band 3
        run_case(24'h12_3456, 32'd3000000, NEVER, 0, 1'b1, 1'b0, 1'b1); // R6 lock timeout
        run_case(24'h65_4321, 32'd1800000, 2, NEVER, 1'b1, 1'b0, 1'b0); // R7 update timeout
        run_case(24'h33_3333, 32'd2000000, 4, 4, 1'b0, 1'b1, 1'b0); // R2 start while busy ignored

        // random cases
        for (int k = 0; k < 14; k++) begin
            run_case(24'($urandom), 32'($urandom_range(1600000, 3200000)),
                     int'($urandom_range(0, 10)), int'($urandom_range(0, 10)),
                     1'b0, 1'b0, 1'b0);
        end

        // R10 read-only instance
        @(negedge clk);
        start_ro = 1'b1;
        @(negedge clk);
        start_ro = 1'b0;
        check(rej_ro === 1'b1 && busy_ro === 1'b0 && req_ro === 1'b0, "R10",
              "refusal pulse", {29'h0, rej_ro, busy_ro, req_ro}, 32'h4);
        @(negedge clk);
        check(rej_ro === 1'b0 && done_ro === 1'b0 && req_ro === 1'b0, "R10",
              "stays quiet", {29'h0, rej_ro, done_ro, req_ro}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule